// File: doc/BRIEF.md
# Clock Source Selector with Crystal Loss Watchdog

This block picks the source of the system clock and protects the chip against losing an external crystal clock. It comes out of reset on the internal RC oscillator. Software can turn on the crystal oscillator and the PLL, then ask for either as the system clock. A request is granted only when the target source is enabled and reports ready. Each granted change parks the clock gate for a fixed number of cycles, so the old clock is stopped before the new one starts.

A watchdog counter runs on the internal reference clock and watches the crystal clock while the guard bit is set, the crystal is enabled and the crystal reports ready. Every rising crystal edge passes through a synchroniser and restarts the counter. If the counter reaches the programmed timeout, the block takes these actions at once:
- it forces the clock back to the RC source;
- it turns off the crystal and the PLL, because the PLL is fed from the crystal;
- it raises a sticky failure flag, which drives a non-maskable interrupt until software clears it.

Software reaches the block through a small register bus. A read returns data one cycle after the read strobe.

Top module: `clk_guard_top`

## Requirements
- R1: After a synchronous reset the block is in this state: the RC source is selected (`sys_sel` = 0), the gate is open, `xtal_en`, `pll_en` and `nmi` are low, the control register reads 0 and the timeout register reads its default (100).
- R2: Writing source code 1 (crystal) to control bits [5:4] switches the clock to the crystal only while control bit 0 (crystal enable) is set and `xtal_ready` is high. Otherwise `sys_sel` stays at its current value.
- R3: Source code 2 (PLL) is granted only while control bit 1 (PLL enable) is set and `pll_ready` is high. Otherwise the current source stays selected.
- R4: A granted switch holds `sys_gate` low for PARK_CYC cycles (default 2). `sys_sel` takes the new value in the same cycle that the gate reopens.
- R5: Status bits [1:0] and the `sys_sel` port always report the source actually driving the clock, using the codes 0 = RC, 1 = crystal and 2 = PLL. Code 3 never appears.
- R6: While monitoring is on and crystal edges keep arriving faster than the timeout, no failure is raised.
- R7: When monitoring is on and no crystal edge is seen for the timeout value (register at address 2) of reference cycles, the block acts in one cycle. It selects RC with the gate open, clears control bits 0 and 1, resets the source request to 0, sets status bit 2 (failure flag) and raises `nmi`. The guard bit is kept.
- R8: The failure flag and `nmi` stay set until software writes status (address 1) with bit 7 set. A write with bit 7 clear leaves the flag set. A failure in the same cycle as a clear leaves the flag set.
- R9: With control bit 2 (guard) clear, a stopped crystal clock raises no failure and leaves the selected source unchanged.
- R10: A write that would clear the enable of the source that is driving the clock is ignored for that bit. This covers the crystal enable while the crystal or the PLL is selected, and the PLL enable while the PLL is selected.
- R11: The register map is as follows:
  - address 0 is control: bit 0 crystal enable, bit 1 PLL enable, bit 2 guard, bits [5:4] source request.
  - address 1 is status: bits [1:0] active source, bit 2 failure flag, bit 3 `xtal_ready`, bit 4 `pll_ready`, bit 5 gate.
  - address 2 is the timeout.
  - `bus_rvalid` pulses one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| xtal_clk | input | 1 | Raw crystal clock, asynchronous |
| xtal_ready | input | 1 | Crystal oscillator stable |
| pll_ready | input | 1 | PLL locked |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| sys_sel | output | 2 | Source driving the system clock |
| sys_gate | output | 1 | System clock gate, low while parked |
| nmi | output | 1 | Non-maskable interrupt, follows the failure flag |

## Verification
The bench asks for the crystal before it is ready and asks for the PLL before it locks. A design that ignores readiness would switch to a dead clock. It counts the parked cycles of a switch; a design that changes the select with the gate open would produce a glitch. It stops the crystal twice, once with the guard clear and once with the guard set. A missing guard qualifier would fire a false interrupt, and a broken counter would never fall back, or would leave the PLL enabled after the fall-back. It also tries to clear the enable of the running source and clears the flag with and without bit 7. A design that lacks the lock would cut its own clock, and a design with a loose clear would lose the interrupt.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2
  } src_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_TMO  = 2'd2;

  // control register fields
  localparam int C_XTAL  = 0;
  localparam int C_PLL   = 1;
  localparam int C_GUARD = 2;
  localparam int C_REQ_L = 4;
  localparam int C_REQ_H = 5;

  // status register fields
  localparam int S_SEL_L = 0;
  localparam int S_SEL_H = 1;
  localparam int S_FAIL  = 2;
  localparam int S_XRDY  = 3;
  localparam int S_PRDY  = 4;
  localparam int S_GATE  = 5;
  localparam int S_CLR   = 7;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  // rising edge seen on the synchronised level
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cg_watch.sv
module cg_watch #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             edge_seen,
  input  logic [TMO_W-1:0] tmo,
  output logic             fail_hit
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt      <= '0;
      fail_hit <= 1'b0;
    end else if (edge_seen) begin
      cnt      <= '0;
      fail_hit <= 1'b0;
    end else if (cnt == tmo) begin
      cnt      <= '0;
      fail_hit <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      fail_hit <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_switch.sv
module cg_switch
  import clk_guard_pkg::*;
#(
  parameter int PARK_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  src_t req,
  input  logic rdy_xtal,
  input  logic rdy_pll,
  input  logic force_rc,
  output src_t sel,
  output src_t tgt,
  output logic gate
);
  localparam int PC_W = (PARK_CYC > 1) ? $clog2(PARK_CYC) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PARK_CYC - 1);

  typedef enum logic {ST_RUN, ST_PARK} sw_st_t;
  sw_st_t        st;
  logic [PC_W-1:0] pc;
  logic          req_rdy;

  always_comb begin
    case (req)
      SRC_RC:   req_rdy = 1'b1;
      SRC_XTAL: req_rdy = rdy_xtal;
      SRC_PLL:  req_rdy = rdy_pll;
      default:  req_rdy = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || force_rc) begin
      st   <= ST_RUN;
      sel  <= SRC_RC;
      tgt  <= SRC_RC;
      gate <= 1'b1;
      pc   <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (req != sel && req_rdy) begin
            st   <= ST_PARK;
            tgt  <= req;
            gate <= 1'b0;
            pc   <= '0;
          end
        end
        default: begin
          if (pc == PC_LAST) begin
            st   <= ST_RUN;
            sel  <= tgt;
            gate <= 1'b1;
          end else begin
            pc <= pc + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/clk_guard_top.sv
module clk_guard_top
  import clk_guard_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          TMO_W    = 8,
  parameter int          SYNC_STG = 2,
  parameter int          PARK_CYC = 2,
  parameter logic [7:0]  DEF_TMO  = 8'd100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              xtal_clk,
  input  logic              xtal_ready,
  input  logic              pll_ready,
  output logic              xtal_en,
  output logic              pll_en,
  output logic [1:0]        sys_sel,
  output logic              sys_gate,
  output logic              nmi
);
  localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(DEF_TMO);

  logic             xtal_on, pll_on, guard_on;
  logic [1:0]       src_req;
  logic [TMO_W-1:0] tmo_q;
  logic             fail_q;
  logic             edge_seen, fail_hit, mon_active;
  logic             lock_xtal, lock_pll;
  logic             wr_ctrl, wr_stat, wr_tmo;
  src_t             sel, tgt;
  logic             gate;
  logic [DATA_W-1:0] rd_n;

  assign wr_ctrl = bus_wr && bus_addr == ADR_CTRL;
  assign wr_stat = bus_wr && bus_addr == ADR_STAT;
  assign wr_tmo  = bus_wr && bus_addr == ADR_TMO;

  assign mon_active = guard_on & xtal_on & xtal_ready;

  cg_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(xtal_clk), .rise(edge_seen)
  );

  cg_watch #(.TMO_W(TMO_W)) u_watch (
    .clk(clk), .rst(rst), .active(mon_active), .edge_seen(edge_seen),
    .tmo(tmo_q), .fail_hit(fail_hit)
  );

  cg_switch #(.PARK_CYC(PARK_CYC)) u_switch (
    .clk(clk), .rst(rst), .req(src_t'(src_req)),
    .rdy_xtal(xtal_on & xtal_ready), .rdy_pll(pll_on & pll_ready),
    .force_rc(fail_hit), .sel(sel), .tgt(tgt), .gate(gate)
  );

  // enables feeding the running or targeted clock cannot be dropped
  assign lock_xtal = (sel != SRC_RC) || (tgt != SRC_RC);
  assign lock_pll  = (sel == SRC_PLL) || (tgt == SRC_PLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_on  <= 1'b0;
      pll_on   <= 1'b0;
      guard_on <= 1'b0;
      src_req  <= SRC_RC;
    end else if (fail_hit) begin
      xtal_on  <= 1'b0;
      pll_on   <= 1'b0;
      src_req  <= SRC_RC;
    end else if (wr_ctrl) begin
      xtal_on  <= bus_wdata[C_XTAL] | (lock_xtal & xtal_on);
      pll_on   <= bus_wdata[C_PLL]  | (lock_pll & pll_on);
      guard_on <= bus_wdata[C_GUARD];
      src_req  <= bus_wdata[C_REQ_H:C_REQ_L];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         tmo_q <= TMO_RST;
    else if (wr_tmo) tmo_q <= bus_wdata[TMO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                             fail_q <= 1'b0;
    else if (fail_hit)                   fail_q <= 1'b1;
    else if (wr_stat && bus_wdata[S_CLR]) fail_q <= 1'b0;
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      ADR_CTRL: begin
        rd_n[C_XTAL]          = xtal_on;
        rd_n[C_PLL]           = pll_on;
        rd_n[C_GUARD]         = guard_on;
        rd_n[C_REQ_H:C_REQ_L] = src_req;
      end
      ADR_STAT: begin
        rd_n[S_SEL_H:S_SEL_L] = sel;
        rd_n[S_FAIL]          = fail_q;
        rd_n[S_XRDY]          = xtal_ready;
        rd_n[S_PRDY]          = pll_ready;
        rd_n[S_GATE]          = gate;
      end
      ADR_TMO:  rd_n[TMO_W-1:0] = tmo_q;
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_n;
    end
  end

  assign xtal_en  = xtal_on;
  assign pll_en   = pll_on;
  assign sys_sel  = sel;
  assign sys_gate = gate;
  assign nmi      = fail_q;
endmodule

// File: rtl/cg_checker.sv
module cg_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sys_sel,
  input logic       sys_gate,
  input logic       xtal_en,
  input logic       pll_en,
  input logic       nmi,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       clr_bit,
  input logic       fail_hit
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sys_sel == 2'd0 && sys_gate && !xtal_en && !pll_en && !nmi));

  assert_xtal_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    sys_sel == 2'd1 |-> xtal_en);

  assert_pll_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    sys_sel == 2'd2 |-> (pll_en && xtal_en));

  assert_parked_switch_R4: assert property (@(posedge clk) disable iff (rst)
    ($changed(sys_sel) && !$past(fail_hit)) |-> $past(!sys_gate));

  assert_legal_sel_R5: assert property (@(posedge clk) disable iff (rst)
    sys_sel != 2'd3);

  assert_fail_forces_rc_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> (sys_sel == 2'd0 && sys_gate && !xtal_en && !pll_en));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (nmi && !(bus_wr && bus_addr == 2'd1 && clr_bit)) |=> nmi);

  assert_fail_wins_R8: assert property (@(posedge clk) disable iff (rst)
    fail_hit |=> nmi);
endmodule

bind clk_guard_top cg_checker u_chk (
  .clk(clk), .rst(rst), .sys_sel(sys_sel), .sys_gate(sys_gate),
  .xtal_en(xtal_en), .pll_en(pll_en), .nmi(nmi), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .clr_bit(bus_wdata[7]), .fail_hit(fail_hit)
);

// File: tb/tb_clk_guard_top.sv
`timescale 1ns/1ps
module tb_clk_guard_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       xtal_clk = 1'b0, xtal_ready = 1'b0, pll_ready = 1'b0;
  logic       xtal_en, pll_en, sys_gate, nmi;
  logic [1:0] sys_sel;
  logic       xtal_run = 1'b0;
  logic       done = 1'b0;

  int errors = 0;
  int checks = 0;

  logic [7:0] q_exp[$];
  logic [7:0] q_mask[$];
  string      q_tag[$];

  clk_guard_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .xtal_clk(xtal_clk), .xtal_ready(xtal_ready),
    .pll_ready(pll_ready), .xtal_en(xtal_en), .pll_en(pll_en),
    .sys_sel(sys_sel), .sys_gate(sys_gate), .nmi(nmi)
  );

  always #2.5 clk = ~clk;

  always begin
    #16;
    if (xtal_run) xtal_clk = ~xtal_clk;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected value into the scoreboard
  task automatic rd_expect(logic [1:0] a, logic [7:0] exp, logic [7:0] mask, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(exp); q_mask.push_back(mask); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pop and compare every returned read
  always @(negedge clk) begin
    if (bus_rvalid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        automatic logic [7:0] e = q_exp.pop_front();
        automatic logic [7:0] m = q_mask.pop_front();
        automatic string      t = q_tag.pop_front();
        if ((bus_rdata & m) != (e & m)) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h mask=%0h", t, bus_rdata & m, e & m, m);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    int low_cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 sys_sel", sys_sel, 0);
    check("R1 sys_gate", sys_gate, 1);
    check("R1 xtal_en", xtal_en, 0);
    check("R1 nmi", nmi, 0);
    rd_expect(2'd0, 8'h00, 8'hFF, "R1 ctrl");
    rd_expect(2'd1, 8'h20, 8'hFF, "R11 status after reset");
    rd_expect(2'd2, 8'd100, 8'hFF, "R1 timeout default");

    // R2 request without enable
    wr(2'd0, 8'h10);
    repeat (8) @(negedge clk);
    check("R2 no enable", sys_sel, 0);
    check("R2 xtal_en off", xtal_en, 0);

    wr(2'd2, 8'd20);
    rd_expect(2'd2, 8'd20, 8'hFF, "R11 timeout write");
    wr(2'd0, 8'h11);
    repeat (8) @(negedge clk);
    check("R2 not ready", sys_sel, 0);
    check("R2 xtal_en on", xtal_en, 1);

    // R4 parked switch
    xtal_run = 1'b1;
    xtal_ready = 1'b1;
    low_cnt = 0;
    lat = 0;
    while (sys_sel != 2'd1 && lat < 50) begin
      @(negedge clk);
      lat++;
      if (!sys_gate) low_cnt++;
    end
    check("R2 switch granted", sys_sel, 1);
    check("R4 parked cycles", low_cnt, 2);
    check("R4 gate reopened", sys_gate, 1);
    rd_expect(2'd1, 8'h01, 8'h07, "R5 status sel xtal");

    // R10 enable of running source is locked
    wr(2'd0, 8'h10);
    rd_expect(2'd0, 8'h11, 8'hFF, "R10 xtal enable kept");
    check("R10 xtal_en", xtal_en, 1);

    // R9 guard off, stopped clock
    xtal_run = 1'b0;
    repeat (100) @(negedge clk);
    check("R9 no nmi", nmi, 0);
    check("R9 sel kept", sys_sel, 1);
    xtal_run = 1'b1;

    // R6 guard on, clock alive
    wr(2'd0, 8'h15);
    repeat (200) @(negedge clk);
    check("R6 no false fail", nmi, 0);
    check("R6 sel kept", sys_sel, 1);

    // R3 PLL readiness
    wr(2'd0, 8'h27);
    repeat (10) @(negedge clk);
    check("R3 pll not ready", sys_sel, 1);
    pll_ready = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 pll granted", sys_sel, 2);
    rd_expect(2'd1, 8'h02, 8'h07, "R5 status sel pll");
    wr(2'd0, 8'h25);
    rd_expect(2'd0, 8'h27, 8'hFF, "R10 pll enable kept");

    // R7 crystal failure
    xtal_run = 1'b0;
    lat = 0;
    while (!nmi && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    check("R7 nmi raised", nmi, 1);
    check("R7 latency in window", (lat >= 18 && lat <= 36) ? 1 : 0, 1);
    check("R7 sel rc", sys_sel, 0);
    check("R7 gate open", sys_gate, 1);
    check("R7 xtal_en off", xtal_en, 0);
    check("R7 pll_en off", pll_en, 0);
    rd_expect(2'd0, 8'h04, 8'hFF, "R7 ctrl after fail");
    rd_expect(2'd1, 8'h04, 8'h07, "R7 status flag");

    // R8 sticky flag
    repeat (20) @(negedge clk);
    check("R8 still set", nmi, 1);
    wr(2'd1, 8'h00);
    check("R8 write without clear bit", nmi, 1);
    wr(2'd1, 8'h80);
    check("R8 cleared", nmi, 0);
    rd_expect(2'd1, 8'h00, 8'h07, "R8 status cleared");

    // R2 recovery path and R11 ready bits
    xtal_run = 1'b1;
    wr(2'd0, 8'h15);
    repeat (12) @(negedge clk);
    check("R2 switch after recovery", sys_sel, 1);
    rd_expect(2'd1, 8'h18, 8'h18, "R11 ready bits");

    repeat (5) @(negedge clk);
    check("R11 scoreboard drained", q_exp.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule